// File: doc/BRIEF.md
# Bidirectional Processor Mailbox

This block carries short messages between an external host processor and an internal core processor. Each direction has its own bank of 16-bit data words, its own command word, its own busy flag and its own interrupt to the receiving side. A sender first reads its status to make sure its outgoing busy flag is clear. It then fills as many data words as the message needs and writes the command word last. That write starts the transfer, marks the direction busy and interrupts the receiver. The receiver reads the words and then writes an acknowledge bit. The acknowledge frees the direction and drops the interrupt.

A command whose top nibble carries the load opcode is treated as a code-load request from host to core. The block does not interrupt the core for it. Instead, it plays the data words out as a stream of program-memory writes. The word count sits in the command's low nibble, and the start address sits in data word 0. A separate DMA channel, programmed by the core, counts bytes against an external controller's acknowledges. It holds a request line while bytes remain, and it records completion in a small interrupt status register that has a mask.

Top module: `proc_mailbox`

## Requirements
- R1: After synchronous reset, host_irq, core_irq, dma_req, dma_irq and load_we are 0, and the status and DMA status registers read 0.
- R2: A command write (address 0x10) to a direction whose busy flag is clear sets that busy flag and raises the receiver's interrupt on the next cycle. Host status bit 0 shows the host's outgoing busy flag and bit 1 shows the incoming busy flag. Core status uses the same layout from the core's view. Status sits at address 0x11.
- R3: The receiver writes 1 to bit 0 of its status register to acknowledge. This clears the incoming busy flag and the receiver's interrupt.
- R4: A command write while that direction is busy is ignored, so the receiver still reads the first command. It also sets the sender's sticky overrun flag (status bit 2). The sender clears that flag by writing 1 to status bit 1.
- R5: Writes by a sender to its data words (addresses 0x00-0x0F) while its direction is busy are ignored.
- R6: The core-to-host direction behaves as in R2-R5, with the roles exchanged and host_irq as the interrupt.
- R7: Each side reads the other side's data words and command at the same addresses it writes its own. Read data appears on the cycle after the address is presented.
- R8: A host command with bits [15:12] = 0xA is a code load and raises no core interrupt. On the n consecutive cycles after the command write, where n is bits [3:0], the block writes data words 1..n to program addresses base+0..base+n-1, with base taken from data word 0. Busy clears with the last write, or one cycle after the command when n = 0, and nothing is written in that case.
- R9: The core writes the byte count minus one to 0x12 and then writes bit 0 = 1 with the direction in bit 1 to 0x13. dma_req rises on the next cycle, stays high for exactly count+1 acknowledged cycles, and falls after the last one.
- R10: Completion sets DMA status bit 0 (direction 0) or bit 1 (direction 1) at 0x14, and the bits are cleared by writing 1. dma_irq is high one cycle after any status bit is set whose mask bit at 0x15 is 0.
- R11: A DMA start while a transfer is active is ignored and sets DMA status bit 2 or 3 for the requested direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after address |
| host_irq | output | 1 | Message pending for the host |
| core_addr | input | 5 | Core register address |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data, one cycle after address |
| core_irq | output | 1 | Message pending for the core |
| load_we | output | 1 | Program-memory write strobe of a code load |
| load_addr | output | 16 | Program-memory write address |
| load_data | output | 16 | Program-memory write data |
| dma_req | output | 1 | DMA service request |
| dma_dir | output | 1 | Direction of the active DMA transfer |
| dma_ack | input | 1 | One byte transferred while dma_req is high |
| dma_irq | output | 1 | Unmasked DMA status pending |

## Verification
The hardest states to reach are the collisions: a second command or a data write landing while a direction is still busy, and a DMA start landing during an active transfer. The stimulus reaches them by holding the acknowledge back on purpose. Randomly chosen messages in both directions are run between these directed collisions. The bench also issues code loads at the extreme counts of 15 and 0 and captures every program-memory write cycle by cycle. DMA transfers use random counts, with idle gaps between acknowledges.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // control register offsets inside the upper address half
  localparam int CTL_CMD  = 0;
  localparam int CTL_STAT = 1;
  localparam int CTL_DCNT = 2;
  localparam int CTL_DCTL = 3;
  localparam int CTL_DIST = 4;
  localparam int CTL_DMSK = 5;
  // status read bits
  localparam int ST_OUT_BUSY = 0;
  localparam int ST_IN_BUSY  = 1;
  localparam int ST_OVR      = 2;
  // status write bits
  localparam int WB_ACK  = 0;
  localparam int WB_CLR  = 1;
  // dma control write bits
  localparam int DC_GO   = 0;
  localparam int DC_DIR  = 1;
endpackage

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int       DW       = 16,
  parameter int       NW       = 16,
  parameter bit       HAS_LOAD = 1'b0,
  parameter bit [3:0] LOAD_OP  = 4'hA
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_word,
  input  logic [$clog2(NW)-1:0]   wr_idx,
  input  logic                    wr_cmd,
  input  logic [DW-1:0]           wr_val,
  input  logic                    ack,
  input  logic                    clr_ovr,
  input  logic [$clog2(NW)-1:0]   rd_idx,
  output logic [DW-1:0]           rd_word,
  output logic [DW-1:0]           cmd_q,
  output logic                    busy_q,
  output logic                    irq_q,
  output logic                    ovr_q,
  output logic                    ld_we,
  output logic [DW-1:0]           ld_addr,
  output logic [DW-1:0]           ld_data
);
  localparam int IW = $clog2(NW);

  logic [DW-1:0] mem [NW];
  logic          take_cmd;
  logic          is_load;
  logic          ld_act;
  logic          ld_done;

  assign take_cmd = wr_cmd && !busy_q;
  assign is_load  = HAS_LOAD && (wr_val[DW-1 -: 4] == LOAD_OP);

  always_ff @(posedge clk) begin
    if (wr_word && !busy_q) mem[wr_idx] <= wr_val;
    rd_word <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      cmd_q  <= '0;
    end else begin
      if (take_cmd) begin
        cmd_q  <= wr_val;
        busy_q <= 1'b1;
        irq_q  <= !is_load;
      end else if (ld_done) begin
        busy_q <= 1'b0;
      end else if (ack && busy_q && !ld_act) begin
        busy_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      if (wr_cmd && busy_q) ovr_q <= 1'b1;
      else if (clr_ovr)     ovr_q <= 1'b0;
    end
  end

  generate
    if (HAS_LOAD) begin : g_load
      logic          act_q;
      logic [IW-1:0] k_q;
      logic [IW-1:0] n_q;
      logic [DW-1:0] base_q;
      logic [DW-1:0] addr_q;
      logic [DW-1:0] data_q;
      logic          we_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          act_q  <= 1'b0;
          k_q    <= '0;
          n_q    <= '0;
          base_q <= '0;
          addr_q <= '0;
          we_q   <= 1'b0;
        end else begin
          we_q <= 1'b0;
          if (wr_word && !busy_q && wr_idx == '0) base_q <= wr_val;
          if (take_cmd && is_load) begin
            act_q <= 1'b1;
            k_q   <= IW'(1);
            n_q   <= wr_val[IW-1:0];
          end else if (act_q) begin
            if (n_q != '0) begin
              we_q   <= 1'b1;
              addr_q <= base_q + DW'(k_q) - DW'(1);
            end
            k_q <= k_q + 1'b1;
            if (n_q == '0 || k_q == n_q) act_q <= 1'b0;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (act_q) data_q <= mem[k_q];
      end

      assign ld_act  = act_q;
      assign ld_done = act_q && (n_q == '0 || k_q == n_q);
      assign ld_we   = we_q;
      assign ld_addr = addr_q;
      assign ld_data = data_q;

      // R8
      load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (busy_q && !irq_q));
    end else begin : g_noload
      assign ld_act  = 1'b0;
      assign ld_done = 1'b0;
      assign ld_we   = 1'b0;
      assign ld_addr = '0;
      assign ld_data = '0;
    end
  endgenerate

  // R2
  cmd_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !busy_q && !is_load) |=> (busy_q && irq_q));
  // R4
  cmd_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && busy_q) |=> (ovr_q && $stable(cmd_q)));
  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && busy_q && !ld_act) |=> (!busy_q && !irq_q));
endmodule

// File: rtl/mbx_dma.sv
module mbx_dma #(
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic             ctl_wr,
  input  logic             ist_wr,
  input  logic             msk_wr,
  input  logic [DW-1:0]    wdata,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic             dma_dir,
  output logic             dma_irq,
  output logic [CNT_W-1:0] cnt_q,
  output logic [3:0]       ist_q,
  output logic [3:0]       msk_q
);
  import mbx_pkg::*;

  logic [CNT_W-1:0] rem_q;
  logic             go;
  logic             start_ok;
  logic             start_bad;
  logic             last;
  logic [3:0]       set_v;
  logic [3:0]       clr_v;

  assign go        = ctl_wr && wdata[DC_GO];
  assign start_ok  = go && !dma_req;
  assign start_bad = go && dma_req;
  assign last      = dma_req && dma_ack && (rem_q == '0);

  always_comb begin
    set_v = '0;
    if (start_bad) set_v[{1'b1, wdata[DC_DIR]}] = 1'b1;
    if (last)      set_v[{1'b0, dma_dir}]       = 1'b1;
    clr_v = ist_wr ? wdata[3:0] : 4'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rem_q   <= '0;
      dma_req <= 1'b0;
      dma_dir <= 1'b0;
      ist_q   <= '0;
      msk_q   <= '0;
      dma_irq <= 1'b0;
    end else begin
      if (cnt_wr && !dma_req) cnt_q <= wdata[CNT_W-1:0];
      if (start_ok) begin
        dma_req <= 1'b1;
        dma_dir <= wdata[DC_DIR];
        rem_q   <= cnt_q;
      end else if (dma_req && dma_ack) begin
        if (rem_q == '0) dma_req <= 1'b0;
        else             rem_q   <= rem_q - 1'b1;
      end
      ist_q <= (ist_q & ~clr_v) | set_v;
      if (msk_wr) msk_q <= wdata[3:0];
      dma_irq <= |(ist_q & ~msk_q);
    end
  end

  // R9
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(start_ok));
  // R9
  req_fall_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> !dma_req);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_bad && !dma_ack) |=> (dma_req && $stable(dma_dir)));
  // R10
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (last && !ist_wr) |=> ist_q[{1'b0, $past(dma_dir)}]);
endmodule

// File: rtl/proc_mailbox.sv
module proc_mailbox #(
  parameter int       DW      = 16,
  parameter int       NW      = 16,
  parameter int       CNT_W   = 16,
  parameter bit [3:0] LOAD_OP = 4'hA
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NW):0]     host_addr,
  input  logic                    host_wr,
  input  logic [DW-1:0]           host_wdata,
  output logic [DW-1:0]           host_rdata,
  output logic                    host_irq,
  input  logic [$clog2(NW):0]     core_addr,
  input  logic                    core_wr,
  input  logic [DW-1:0]           core_wdata,
  output logic [DW-1:0]           core_rdata,
  output logic                    core_irq,
  output logic                    load_we,
  output logic [DW-1:0]           load_addr,
  output logic [DW-1:0]           load_data,
  output logic                    dma_req,
  output logic                    dma_dir,
  input  logic                    dma_ack,
  output logic                    dma_irq
);
  import mbx_pkg::*;
  localparam int IW = $clog2(NW);

  logic          h_ctl, c_ctl;
  logic [IW-1:0] h_off, c_off;
  logic          h_word_wr, h_cmd_wr, h_stat_wr;
  logic          c_word_wr, c_cmd_wr, c_stat_wr;
  logic          c_cnt_wr, c_dctl_wr, c_ist_wr, c_msk_wr;

  assign h_ctl     = host_addr[IW];
  assign h_off     = host_addr[IW-1:0];
  assign c_ctl     = core_addr[IW];
  assign c_off     = core_addr[IW-1:0];
  assign h_word_wr = host_wr && !h_ctl;
  assign h_cmd_wr  = host_wr && h_ctl && (h_off == IW'(CTL_CMD));
  assign h_stat_wr = host_wr && h_ctl && (h_off == IW'(CTL_STAT));
  assign c_word_wr = core_wr && !c_ctl;
  assign c_cmd_wr  = core_wr && c_ctl && (c_off == IW'(CTL_CMD));
  assign c_stat_wr = core_wr && c_ctl && (c_off == IW'(CTL_STAT));
  assign c_cnt_wr  = core_wr && c_ctl && (c_off == IW'(CTL_DCNT));
  assign c_dctl_wr = core_wr && c_ctl && (c_off == IW'(CTL_DCTL));
  assign c_ist_wr  = core_wr && c_ctl && (c_off == IW'(CTL_DIST));
  assign c_msk_wr  = core_wr && c_ctl && (c_off == IW'(CTL_DMSK));

  logic [DW-1:0] h2c_rd, h2c_cmd, c2h_rd, c2h_cmd;
  logic          h2c_busy, h2c_irq, h2c_ovr;
  logic          c2h_busy, c2h_irq, c2h_ovr;
  logic          unused_c2h_we;
  logic [DW-1:0] unused_c2h_a, unused_c2h_d;

  mbx_chan #(.DW(DW), .NW(NW), .HAS_LOAD(1'b1), .LOAD_OP(LOAD_OP)) u_h2c (
    .clk(clk), .rst(rst),
    .wr_word(h_word_wr), .wr_idx(h_off), .wr_cmd(h_cmd_wr), .wr_val(host_wdata),
    .ack(c_stat_wr && core_wdata[WB_ACK]),
    .clr_ovr(h_stat_wr && host_wdata[WB_CLR]),
    .rd_idx(c_off), .rd_word(h2c_rd), .cmd_q(h2c_cmd),
    .busy_q(h2c_busy), .irq_q(h2c_irq), .ovr_q(h2c_ovr),
    .ld_we(load_we), .ld_addr(load_addr), .ld_data(load_data)
  );

  mbx_chan #(.DW(DW), .NW(NW), .HAS_LOAD(1'b0), .LOAD_OP(LOAD_OP)) u_c2h (
    .clk(clk), .rst(rst),
    .wr_word(c_word_wr), .wr_idx(c_off), .wr_cmd(c_cmd_wr), .wr_val(core_wdata),
    .ack(h_stat_wr && host_wdata[WB_ACK]),
    .clr_ovr(c_stat_wr && core_wdata[WB_CLR]),
    .rd_idx(h_off), .rd_word(c2h_rd), .cmd_q(c2h_cmd),
    .busy_q(c2h_busy), .irq_q(c2h_irq), .ovr_q(c2h_ovr),
    .ld_we(unused_c2h_we), .ld_addr(unused_c2h_a), .ld_data(unused_c2h_d)
  );

  logic [CNT_W-1:0] d_cnt;
  logic [3:0]       d_ist, d_msk;

  mbx_dma #(.DW(DW), .CNT_W(CNT_W)) u_dma (
    .clk(clk), .rst(rst),
    .cnt_wr(c_cnt_wr), .ctl_wr(c_dctl_wr), .ist_wr(c_ist_wr), .msk_wr(c_msk_wr),
    .wdata(core_wdata), .dma_ack(dma_ack),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_irq(dma_irq),
    .cnt_q(d_cnt), .ist_q(d_ist), .msk_q(d_msk)
  );

  assign host_irq = c2h_irq;
  assign core_irq = h2c_irq;

  logic [DW-1:0] h_ctl_v, c_ctl_v, h_ctl_q, c_ctl_q;
  logic          h_sel_q, c_sel_q;

  always_comb begin
    h_ctl_v = '0;
    if (h_off == IW'(CTL_CMD)) h_ctl_v = c2h_cmd;
    else if (h_off == IW'(CTL_STAT)) begin
      h_ctl_v[ST_OUT_BUSY] = h2c_busy;
      h_ctl_v[ST_IN_BUSY]  = c2h_busy;
      h_ctl_v[ST_OVR]      = h2c_ovr;
    end
  end

  always_comb begin
    c_ctl_v = '0;
    case (c_off)
      IW'(CTL_CMD):  c_ctl_v = h2c_cmd;
      IW'(CTL_STAT): begin
        c_ctl_v[ST_OUT_BUSY] = c2h_busy;
        c_ctl_v[ST_IN_BUSY]  = h2c_busy;
        c_ctl_v[ST_OVR]      = c2h_ovr;
      end
      IW'(CTL_DCNT): c_ctl_v = DW'(d_cnt);
      IW'(CTL_DCTL): c_ctl_v = DW'({dma_dir, dma_req});
      IW'(CTL_DIST): c_ctl_v = DW'(d_ist);
      IW'(CTL_DMSK): c_ctl_v = DW'(d_msk);
      default:       c_ctl_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sel_q <= 1'b1;
      c_sel_q <= 1'b1;
      h_ctl_q <= '0;
      c_ctl_q <= '0;
    end else begin
      h_sel_q <= h_ctl;
      c_sel_q <= c_ctl;
      h_ctl_q <= h_ctl_v;
      c_ctl_q <= c_ctl_v;
    end
  end

  assign host_rdata = h_sel_q ? h_ctl_q : c2h_rd;
  assign core_rdata = c_sel_q ? c_ctl_q : h2c_rd;
endmodule

// File: tb/sim_proc_mailbox.sv
`timescale 1ns/1ps
module sim_proc_mailbox;
  localparam logic [4:0] A_CMD = 5'h10, A_STAT = 5'h11, A_DCNT = 5'h12,
                         A_DCTL = 5'h13, A_DIST = 5'h14, A_DMSK = 5'h15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [4:0] host_addr, core_addr;
  logic host_wr, core_wr, dma_ack;
  logic [15:0] host_wdata, core_wdata, host_rdata, core_rdata;
  logic host_irq, core_irq, load_we, dma_req, dma_dir, dma_irq;
  logic [15:0] load_addr, load_data;

  proc_mailbox u0 (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .core_addr(core_addr), .core_wr(core_wr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_irq(core_irq),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_ack(dma_ack), .dma_irq(dma_irq)
  );

  int n_run = 0, n_fail = 0;
  logic [15:0] mh [16];
  logic [15:0] mc [16];
  logic [15:0] cap_a [16];
  logic [15:0] cap_d [16];
  int ncap = 0;
  bit irq_seen = 0;

  always @(negedge clk) begin
    if (load_we && ncap < 16) begin
      cap_a[ncap] = load_addr;
      cap_d[ncap] = load_data;
      ncap++;
    end
    if (core_irq) irq_seen = 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cw(input logic [4:0] a, input logic [15:0] d);
    core_addr = a; core_wdata = d; core_wr = 1'b1;
    @(negedge clk);
    core_wr = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [15:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic cr(input logic [4:0] a, output logic [15:0] d);
    core_addr = a;
    @(negedge clk);
    d = core_rdata;
  endtask

  function automatic logic [15:0] plain_cmd(input logic [15:0] v);
    logic [15:0] r = v;
    if (r[15:12] == 4'hA) r[15:12] = 4'h3;
    return r;
  endfunction

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic dma_run(input int cnt, input bit dir, input string tag);
    int acks = 0;
    cw(A_DCNT, 16'(cnt));
    cw(A_DCTL, {14'd0, dir, 1'b1});
    chk({tag, " req raised"}, {31'd0, dma_req}, 32'd1);
    chk({tag, " dir"}, {31'd0, dma_dir}, {31'd0, dir});
    while (dma_req && acks < cnt + 5) begin
      if ($urandom % 3 == 0) @(negedge clk);
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      acks++;
    end
    chk({tag, " ack count"}, 32'(acks), 32'(cnt + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [15:0] r;
    int s;
    s = $urandom(32'd20250611);
    rst = 1'b1; host_wr = 0; core_wr = 0; dma_ack = 0;
    host_addr = '0; core_addr = '0; host_wdata = '0; core_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irqs", {28'd0, host_irq, core_irq, dma_req, dma_irq}, 32'd0);
    chk("R1 load_we", {31'd0, load_we}, 32'd0);
    hr(A_STAT, r); chk("R1 host status", r, 0);
    cr(A_STAT, r); chk("R1 core status", r, 0);
    cr(A_DIST, r); chk("R1 dma status", r, 0);

    // R2 / R7 host to core message
    for (int i = 0; i < 4; i++) begin mh[i] = 16'h1100 + 16'(i); hw(5'(i), mh[i]); end
    hw(A_CMD, 16'h1234);
    chk("R2 core_irq next cycle", {31'd0, core_irq}, 32'd1);
    hr(A_STAT, r); chk("R2 host status", r, 16'h0001);
    cr(A_STAT, r); chk("R2 core status", r, 16'h0002);
    cr(5'd2, r);   chk("R7 core reads word 2", r, mh[2]);
    cr(A_CMD, r);  chk("R7 core reads cmd", r, 16'h1234);

    // R5 data write while busy ignored
    hw(5'd3, 16'hDEAD);
    cr(5'd3, r); chk("R5 word kept while busy", r, mh[3]);

    // R4 command while busy
    hw(A_CMD, 16'h5555);
    cr(A_CMD, r);  chk("R4 first cmd kept", r, 16'h1234);
    hr(A_STAT, r); chk("R4 overrun set", r, 16'h0005);
    hw(A_STAT, 16'h0002);
    hr(A_STAT, r); chk("R4 overrun cleared", r, 16'h0001);

    // R3 acknowledge
    cw(A_STAT, 16'h0001);
    chk("R3 core_irq cleared", {31'd0, core_irq}, 32'd0);
    hr(A_STAT, r); chk("R3 host busy cleared", r, 0);

    // R6 reverse direction
    for (int i = 0; i < 3; i++) begin mc[i] = 16'h2200 + 16'(i); cw(5'(i), mc[i]); end
    cw(A_CMD, 16'h0BEE);
    chk("R6 host_irq", {31'd0, host_irq}, 32'd1);
    cw(5'd1, 16'hFFFF);
    cw(A_CMD, 16'h0001);
    hr(5'd1, r);   chk("R6 word kept", r, mc[1]);
    hr(A_CMD, r);  chk("R6 cmd kept", r, 16'h0BEE);
    cr(A_STAT, r); chk("R6 core overrun", r, 16'h0005);
    hw(A_STAT, 16'h0001);
    chk("R6 host_irq cleared", {31'd0, host_irq}, 32'd0);
    cw(A_STAT, 16'h0002);
    cr(A_STAT, r); chk("R6 core status clean", r, 0);

    // random messages in both directions
    for (int it = 0; it < 30; it++) begin
      bit dir = 1'($urandom % 2);
      int nw = int'($urandom % 5);
      logic [3:0] idx = 4'($urandom % 16);
      logic [15:0] v = 16'($urandom);
      logic [15:0] c = plain_cmd(16'($urandom));
      for (int k = 0; k < nw; k++) begin
        idx = 4'($urandom % 16); v = 16'($urandom);
        if (dir) begin mc[idx] = v; cw({1'b0, idx}, v); end
        else     begin mh[idx] = v; hw({1'b0, idx}, v); end
      end
      if (dir) begin
        cw(A_CMD, c);
        chk("R6 rand irq", {31'd0, host_irq}, 32'd1);
        hr(A_CMD, r); chk("R7 rand cmd", r, c);
        if (nw > 0) begin hr({1'b0, idx}, r); chk("R7 rand word", r, mc[idx]); end
        hw(A_STAT, 16'h0001);
        chk("R3 rand ack", {31'd0, host_irq}, 32'd0);
      end else begin
        hw(A_CMD, c);
        chk("R2 rand irq", {31'd0, core_irq}, 32'd1);
        cr(A_CMD, r); chk("R7 rand cmd", r, c);
        if (nw > 0) begin cr({1'b0, idx}, r); chk("R7 rand word", r, mh[idx]); end
        cw(A_STAT, 16'h0001);
        chk("R3 rand ack", {31'd0, core_irq}, 32'd0);
      end
    end

    // R8 code load, 15 words
    mh[0] = 16'h0200; hw(5'd0, mh[0]);
    for (int i = 1; i < 16; i++) begin mh[i] = 16'(($urandom % 65536)); hw(5'(i), mh[i]); end
    ncap = 0; irq_seen = 0;
    hw(A_CMD, 16'hA00F);
    repeat (18) @(negedge clk);
    chk("R8 write count 15", 32'(ncap), 32'd15);
    for (int i = 0; i < 15; i++) begin
      chk("R8 load addr", cap_a[i], 16'h0200 + 16'(i));
      chk("R8 load data", cap_d[i], mh[i + 1]);
    end
    chk("R8 no core irq", {31'd0, irq_seen}, 32'd0);
    hr(A_STAT, r); chk("R8 busy cleared", r, 0);

    // R8 code load, zero words
    ncap = 0;
    hw(A_CMD, 16'hA000);
    repeat (3) @(negedge clk);
    chk("R8 zero count writes", 32'(ncap), 32'd0);
    hr(A_STAT, r); chk("R8 zero count busy", r, 0);
    chk("R8 zero count irq", {31'd0, irq_seen}, 32'd0);

    // R9 / R11 DMA with a rejected start
    cw(A_DCNT, 16'd4);
    cw(A_DCTL, 16'h0001);
    chk("R9 req after start", {31'd0, dma_req}, 32'd1);
    cw(A_DCTL, 16'h0003);
    chk("R11 dir unchanged", {31'd0, dma_dir}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      chk("R9 req held", {31'd0, dma_req}, 32'd1);
      dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
      if (i == 2) @(negedge clk);
    end
    chk("R9 req dropped", {31'd0, dma_req}, 32'd0);
    @(negedge clk);
    chk("R10 dma_irq", {31'd0, dma_irq}, 32'd1);
    cr(A_DIST, r); chk("R10 R11 status bits", r, 16'h0009);
    cw(A_DIST, 16'h000F);
    cr(A_DIST, r); chk("R10 cleared", r, 0);
    chk("R10 irq dropped", {31'd0, dma_irq}, 32'd0);

    // R10 mask
    cw(A_DMSK, 16'h0002);
    dma_run(0, 1'b1, "R9 single byte");
    repeat (2) @(negedge clk);
    chk("R10 masked irq", {31'd0, dma_irq}, 32'd0);
    cr(A_DIST, r); chk("R10 masked status", r, 16'h0002);
    cw(A_DMSK, 16'h0000);
    @(negedge clk);
    chk("R10 unmasked irq", {31'd0, dma_irq}, 32'd1);
    cw(A_DIST, 16'h000F);

    // random DMA transfers
    for (int it = 0; it < 6; it++) begin
      dma_run(int'($urandom % 21), 1'($urandom % 2), "R9 random");
      cw(A_DIST, 16'h000F);
    end

    report();
    $finish;
  end
endmodule